// File: doc/BRIEF.md
# Microcoded Interpolation Sequencer

This block is a wide-word microprogrammed engine for the setup stage of a polygon shader. A writable store of 1024 words, each 80 bits, holds both the program and its working data. Every word carries two 32-bit data fields plus five control fields. One word executes per clock. The primary operations are fixed-point interpolation steps, counted loops, patching of fields in other words, and two handshake waits. The sideband fields of each executed word go out to the frame-buffer interface and the span-shader ports, along with the word's first data field as it was before the primary operation changed it.

An external initialiser loads and patches words through a host write port, then raises `run`. The program advances from word 0. Interpolation results are written back into the operand field of the word that produced them, so a loop body accumulates across passes without any separate register file. The frame-buffer memory and the span arithmetic are outside this block; they appear only as handshake signals.

Top module: `interp_seq`

## Requirements
- R1: Word layout: bits 31..0 are data field A, 63..32 data field B, 67..64 the opcode, 68 the interface select, 70..69 the access type, 75..71 the register select, 79..76 the counter code. Opcode 1 (interpolate) writes A+B, modulo 2^32, back into A of the same word. It also records whether adding the low 16 bits of A and B carried into bit 16.
- R2: Opcode 2 (span-count interpolate) writes A+B into A when the most recent opcode-1 word recorded no carry. When it did record a carry, it writes A+B-0x10000. Opcode 2 does not change the recorded carry.
- R3: Opcode 4 (repeat) writes A-1 back into A. When that new value is zero or positive as a signed number, it branches to the word addressed by the low 10 bits of B. Otherwise it falls through to the next word.
- R4: Opcode 3 (write constant) stores A of the current word into the word addressed by the low 10 bits of B. It writes field B of that word when bit 31 of B is set, and field A when it is clear.
- R5: When a word executes, `ex_vld` pulses on the next clock. `ex_pc` carries the word's address, `ex_side` carries bits 79..68, and `ex_val` carries field A as it was before the primary operation, so the register write comes ahead of the operation.
- R6: A word that executes takes one clock. A taken repeat takes two clocks, and its second clock executes nothing.
- R7: A word whose register select is 16 (span count) holds, with no side effects, until `span_rdy` is high. When it executes, `span_go` pulses together with `ex_vld`.
- R8: Opcode 6 raises `sync2_req` while it waits. It completes on a clock where `sync2_ack` is high.
- R9: Opcode 5 holds until the host port writes its own address. The following clock moves to the next word without executing anything.
- R10: Opcode 7 raises `done`, which stays high until reset. No word executes after it. Opcodes 0 and 8..15 perform no primary operation and execution continues at the next word.
- R11: After reset, `ex_vld`, `span_go`, `sync2_req` and `done` are low and execution starts at word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables execution |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 10 | Host write word address |
| hw_word | input | 80 | Host write data, a whole word |
| span_rdy | input | 1 | Span unit can accept a new count |
| sync2_ack | input | 1 | Downstream processor acknowledge |
| ex_vld | output | 1 | A word executed on the previous clock |
| ex_pc | output | 10 | Address of the executed word |
| ex_side | output | 12 | Sideband fields of the executed word |
| ex_val | output | 32 | Field A of the executed word before its operation |
| span_go | output | 1 | Span count issued |
| sync2_req | output | 1 | Waiting for downstream acknowledge |
| done | output | 1 | Halt reached |

## Verification
The properties assume that `span_rdy` and `sync2_ack` are stable levels sampled at the clock. They also assume that the host does not rewrite a word in the same cycle it executes, except to release a SYNC1 wait. The stimulus loads the whole program before `run` rises. It changes the handshake inputs and the releasing host write only on falling edges, and only while the engine is parked on the matching wait. Each input is raised only after the outputs show that the stall has taken hold.

// File: rtl/interp_seq_pkg.sv
package interp_seq_pkg;

   typedef enum logic [3:0] {
      OP_NOP   = 4'd0,
      OP_IP    = 4'd1,
      OP_IPSC  = 4'd2,
      OP_WC    = 4'd3,
      OP_REP   = 4'd4,
      OP_SYNC1 = 4'd5,
      OP_SYNC2 = 4'd6,
      OP_HALT  = 4'd7
   } seq_op_e;

   localparam logic [4:0] RS_SPAN_CNT = 5'd16;
   localparam int         SIDE_W      = 12;

endpackage

// File: rtl/iseq_alu.sv
module iseq_alu
   import interp_seq_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [3:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          carry_in,
   output logic [DW-1:0] res,
   output logic          carry_out,
   output logic          taken
);

   localparam logic [DW-1:0] UNIT = {{(DW-17){1'b0}}, 1'b1, 16'h0000};

   logic [DW-1:0] sum;
   logic [16:0]   lo;

   always_comb begin
      sum       = a + b;
      lo        = {1'b0, a[15:0]} + {1'b0, b[15:0]};
      carry_out = lo[16];
      res       = a;
      taken     = 1'b0;
      case (op)
         OP_IP:   res = sum;
         OP_IPSC: res = carry_in ? sum - UNIT : sum;
         OP_WC:   res = a;
         OP_REP: begin
            res   = a - 1'b1;
            taken = ~res[DW-1];
         end
         default: res = a;
      endcase
   end

endmodule

// File: rtl/iseq_store.sv
module iseq_store #(
   parameter int AW = 10,
   parameter int DW = 32,
   parameter int WW = 80
) (
   input  logic          clk,
   input  logic [AW-1:0] rd_addr,
   output logic [WW-1:0] rd_word,
   input  logic          iw_en,
   input  logic [AW-1:0] iw_addr,
   input  logic          iw_hi,
   input  logic [DW-1:0] iw_val,
   input  logic          hw_en,
   input  logic [AW-1:0] hw_addr,
   input  logic [WW-1:0] hw_word
);

   localparam int DEPTH = 1 << AW;

   logic [WW-1:0] mem [DEPTH];

   // Internal field write first; a host write to the same word lands later and wins.
   always_ff @(posedge clk) begin
      if (iw_en) begin
         if (iw_hi) mem[iw_addr][2*DW-1:DW] <= iw_val;
         else       mem[iw_addr][DW-1:0]    <= iw_val;
      end
      if (hw_en) mem[hw_addr] <= hw_word;
   end

   assign rd_word = mem[rd_addr];

endmodule

// File: rtl/interp_seq.sv
module interp_seq
   import interp_seq_pkg::*;
#(
   parameter int AW = 10,
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic                 hw_en,
   input  logic [AW-1:0]        hw_addr,
   input  logic [2*DW+15:0]     hw_word,
   input  logic                 span_rdy,
   input  logic                 sync2_ack,
   output logic                 ex_vld,
   output logic [AW-1:0]        ex_pc,
   output logic [SIDE_W-1:0]    ex_side,
   output logic [DW-1:0]        ex_val,
   output logic                 span_go,
   output logic                 sync2_req,
   output logic                 done
);

   localparam int WW     = 2*DW + 16;
   localparam int OP_LSB = 2*DW;
   localparam int SD_LSB = 2*DW + 4;
   localparam int RS_LSB = 2*DW + 7;

   if (DW < 24 || AW >= DW) begin : g_bad_cfg
      $error("interp_seq: DW must be at least 24 and exceed AW");
   end

   logic [AW-1:0] pc_q;
   logic          bubble_q, hit_q, carry_q, done_q;
   logic [WW-1:0] cur;
   logic [3:0]    op;
   logic [4:0]    rs;
   logic [DW-1:0] dw1, dw2, alu_res;
   logic          alu_c, taken;
   logic          go, sn_blk, s2_blk, is_s1, exec, hw_hits;
   logic          iw_en, iw_hi;
   logic [AW-1:0] iw_addr;
   logic [DW-1:0] iw_val;

   assign op  = cur[OP_LSB +: 4];
   assign rs  = cur[RS_LSB +: 5];
   assign dw1 = cur[DW-1:0];
   assign dw2 = cur[2*DW-1:DW];

   assign go      = run & ~done_q & ~bubble_q;
   assign is_s1   = (op == OP_SYNC1);
   assign sn_blk  = (rs == RS_SPAN_CNT) & ~span_rdy;
   assign s2_blk  = (op == OP_SYNC2) & ~sync2_ack;
   assign exec    = go & ~hit_q & ~is_s1 & ~sn_blk & ~s2_blk;
   assign hw_hits = hw_en & (hw_addr == pc_q);

   assign sync2_req = go & ~hit_q & ~sn_blk & (op == OP_SYNC2);
   assign done      = done_q;

   iseq_alu #(.DW(DW)) u_alu (
      .op        (op),
      .a         (dw1),
      .b         (dw2),
      .carry_in  (carry_q),
      .res       (alu_res),
      .carry_out (alu_c),
      .taken     (taken)
   );

   always_comb begin
      iw_en   = exec & ((op == OP_IP) | (op == OP_IPSC) | (op == OP_REP) | (op == OP_WC));
      iw_addr = (op == OP_WC) ? dw2[AW-1:0] : pc_q;
      iw_hi   = (op == OP_WC) & dw2[DW-1];
      iw_val  = alu_res;
   end

   iseq_store #(.AW(AW), .DW(DW), .WW(WW)) u_store (
      .clk     (clk),
      .rd_addr (pc_q),
      .rd_word (cur),
      .iw_en   (iw_en),
      .iw_addr (iw_addr),
      .iw_hi   (iw_hi),
      .iw_val  (iw_val),
      .hw_en   (hw_en),
      .hw_addr (hw_addr),
      .hw_word (hw_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= '0;
         bubble_q <= 1'b0;
         hit_q    <= 1'b0;
         carry_q  <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         bubble_q <= exec & taken;
         if (go) begin
            if (hit_q) begin
               pc_q  <= pc_q + 1'b1;
               hit_q <= 1'b0;
            end else if (is_s1 && hw_hits) begin
               hit_q <= 1'b1;
            end else if (exec) begin
               pc_q <= taken ? dw2[AW-1:0] : pc_q + 1'b1;
               if (op == OP_IP)   carry_q <= alu_c;
               if (op == OP_HALT) done_q  <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_vld  <= 1'b0;
         span_go <= 1'b0;
         ex_pc   <= '0;
         ex_side <= '0;
         ex_val  <= '0;
      end else begin
         ex_vld  <= exec;
         span_go <= exec & (rs == RS_SPAN_CNT);
         if (exec) begin
            ex_pc   <= pc_q;
            ex_side <= cur[WW-1:SD_LSB];
            ex_val  <= dw1;
         end
      end
   end

endmodule

// File: rtl/interp_seq_chk.sv
module interp_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic bubble_q,
   input logic hit_q,
   input logic ex_vld,
   input logic span_go,
   input logic span_rdy,
   input logic sync2_req,
   input logic sync2_ack,
   input logic done
);

   // R6
   bubble_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_q |=> !ex_vld);

   // R7
   span_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      span_go |-> $past(span_rdy));

   // R7
   span_with_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      span_go |-> ex_vld);

   // R8
   sync2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync2_req && !sync2_ack) |=> !ex_vld);

   // R9
   sync1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |=> !ex_vld);

   // R10
   halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !ex_vld));

endmodule

bind interp_seq interp_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bubble_q  (bubble_q),
   .hit_q     (hit_q),
   .ex_vld    (ex_vld),
   .span_go   (span_go),
   .span_rdy  (span_rdy),
   .sync2_req (sync2_req),
   .sync2_ack (sync2_ack),
   .done      (done)
);

// File: tb/sim_interp_seq.sv
`timescale 1ns/1ps
module sim_interp_seq;
   import interp_seq_pkg::*;

   localparam int AW = 10;
   localparam int DW = 32;
   localparam int WW = 2*DW + 16;

   logic clk = 1'b0;
   logic rst_n, run, hw_en, span_rdy, sync2_ack;
   logic [AW-1:0] hw_addr;
   logic [WW-1:0] hw_word;
   logic ex_vld, span_go, sync2_req, done;
   logic [AW-1:0] ex_pc;
   logic [11:0]   ex_side;
   logic [DW-1:0] ex_val;

   always #2.5 clk = ~clk;

   interp_seq u0 (
      .clk(clk), .rst_n(rst_n), .run(run), .hw_en(hw_en), .hw_addr(hw_addr),
      .hw_word(hw_word), .span_rdy(span_rdy), .sync2_ack(sync2_ack),
      .ex_vld(ex_vld), .ex_pc(ex_pc), .ex_side(ex_side), .ex_val(ex_val),
      .span_go(span_go), .sync2_req(sync2_req), .done(done)
   );

   typedef struct packed {
      logic [AW-1:0]     pc;
      logic [DW-1:0]     val;
      logic [11:0]       side;
      logic              sg;
      logic signed [7:0] gap;
   } exp_t;

   exp_t  q[$];
   string tq[$];
   int    n_chk = 0, n_bad = 0, since = 0;
   bit    ended = 0;

   function automatic logic [11:0] sd(logic fis, logic [1:0] fza, logic [4:0] irs, logic [3:0] icm);
      return {icm, irs, fza, fis};
   endfunction

   function automatic logic [WW-1:0] mkw(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [11:0] s);
      return {s, op, b, a};
   endfunction

   task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic push(logic [AW-1:0] pc, logic [DW-1:0] v, logic [11:0] s, logic sg, int gap, string tag);
      exp_t e;
      e.pc = pc; e.val = v; e.side = s; e.sg = sg; e.gap = 8'(gap);
      q.push_back(e);
      tq.push_back(tag);
   endtask

   task automatic hwr(logic [AW-1:0] a, logic [WW-1:0] w);
      @(negedge clk);
      hw_en = 1'b1; hw_addr = a; hw_word = w;
      @(negedge clk);
      hw_en = 1'b0;
   endtask

   task automatic drain();
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   // Monitor: pops the scoreboard on every executed word
   always @(negedge clk) begin
      if (rst_n) begin
         since++;
         if (ex_vld) begin
            if (q.size() == 0) begin
               chk(1'b0, "R6 unexpected execution pc", 64'(ex_pc), 64'hFFFF);
            end else begin
               exp_t e;
               string t;
               e = q.pop_front();
               t = tq.pop_front();
               chk(ex_pc == e.pc, {t, " pc"}, 64'(ex_pc), 64'(e.pc));
               chk(ex_val == e.val, {t, " value"}, 64'(ex_val), 64'(e.val));
               chk(ex_side == e.side, {t, " R5 sideband"}, 64'(ex_side), 64'(e.side));
               chk(span_go == e.sg, {t, " R7 span_go"}, 64'(span_go), 64'(e.sg));
               if (e.gap >= 0)
                  chk(since == int'(e.gap), {t, " R6 clocks"}, 64'(since), 64'(e.gap));
            end
            since = 0;
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      chk(1'b0, "watchdog R6", 64'(q.size()), 64'd0);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; run = 1'b0; hw_en = 1'b0; hw_addr = '0; hw_word = '0;
      span_rdy = 1'b0; sync2_ack = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(!ex_vld && !span_go && !sync2_req && !done, "R11 reset outputs",
          64'({ex_vld, span_go, sync2_req, done}), 64'd0);

      hwr(0,  mkw(OP_WC,    32'h0000CAFE, 32'h00000005, sd(1'b1, 2'd2, 5'd3, 4'd5)));
      hwr(1,  mkw(OP_WC,    32'h00000003, 32'h80000006, 12'h0));
      hwr(2,  mkw(OP_IP,    32'h00008000, 32'h00009000, 12'h0));
      hwr(3,  mkw(OP_IPSC,  32'h00050000, 32'h00020000, 12'h0));
      hwr(4,  mkw(OP_IP,    32'h00000007, 32'h00000001, 12'h0));
      hwr(5,  mkw(OP_IPSC,  32'h00001111, 32'h00000010, 12'h0));
      hwr(6,  mkw(OP_IP,    32'h00000100, 32'h00000000, 12'h0));
      hwr(7,  mkw(OP_REP,   32'h00000001, 32'h00000002, 12'h0));
      hwr(8,  mkw(OP_NOP,   32'h00000009, 32'h0, sd(1'b0, 2'd0, RS_SPAN_CNT, 4'd0)));
      hwr(9,  mkw(OP_SYNC2, 32'h00000000, 32'h0, 12'h0));
      hwr(10, mkw(OP_SYNC1, 32'h00000000, 32'h0, 12'h0));
      hwr(11, mkw(4'hF,     32'h00000055, 32'h0, 12'h0));
      hwr(12, mkw(OP_HALT,  32'h00000000, 32'h0, 12'h0));

      push(0, 32'h0000CAFE, sd(1'b1, 2'd2, 5'd3, 4'd5), 0, -1, "R5 first word");
      push(1, 32'h00000003, 12'h0, 0, 1, "R4 write-constant B");
      push(2, 32'h00008000, 12'h0, 0, 1, "R1 ip pass1");
      push(3, 32'h00050000, 12'h0, 0, 1, "R2 ipsc pass1");
      push(4, 32'h00000007, 12'h0, 0, 1, "R1 ip small");
      push(5, 32'h0000CAFE, 12'h0, 0, 1, "R4 field A patched");
      push(6, 32'h00000100, 12'h0, 0, 1, "R6 one clock");
      push(7, 32'h00000001, 12'h0, 0, 1, "R3 repeat taken");
      push(2, 32'h00011000, 12'h0, 0, 2, "R1 ip writeback");
      push(3, 32'h00060000, 12'h0, 0, 1, "R2 carry adjusted");
      push(4, 32'h00000008, 12'h0, 0, 1, "R1 ip writeback small");
      push(5, 32'h0000CB0E, 12'h0, 0, 1, "R2 plain sum");
      push(6, 32'h00000103, 12'h0, 0, 1, "R4 field B patched");
      push(7, 32'h00000000, 12'h0, 0, 1, "R3 repeat falls through");
      @(negedge clk);
      run = 1'b1;
      drain();

      repeat (4) @(negedge clk);
      chk(!ex_vld && !sync2_req, "R7 span wait holds", 64'({ex_vld, sync2_req}), 64'd0);
      push(8, 32'h00000009, sd(1'b0, 2'd0, RS_SPAN_CNT, 4'd0), 1, -1, "R7 span issue");
      span_rdy = 1'b1;
      drain();

      repeat (3) @(negedge clk);
      chk(sync2_req == 1'b1 && !ex_vld, "R8 request raised", 64'({sync2_req, ex_vld}), 64'h2);
      push(9, 32'h00000000, 12'h0, 0, -1, "R8 sync2 complete");
      sync2_ack = 1'b1;
      @(negedge clk);
      sync2_ack = 1'b0;
      drain();

      repeat (4) @(negedge clk);
      chk(!done && !sync2_req && !ex_vld, "R9 sync1 holds", 64'({done, sync2_req, ex_vld}), 64'd0);
      push(11, 32'h00000055, 12'h0, 0, -1, "R10 unlisted opcode");
      push(12, 32'h00000000, 12'h0, 0, 1, "R10 halt word");
      hwr(10, mkw(OP_NOP, 32'h0, 32'h0, 12'h0));
      drain();

      repeat (4) @(negedge clk);
      chk(done == 1'b1, "R10 done raised", 64'(done), 64'd1);
      chk(q.size() == 0, "R10 nothing after halt", 64'(q.size()), 64'd0);
      finish_run();
   end

endmodule